// File: doc/BRIEF.md
# Subranging Code Corrector

This block turns the two 7-bit codes of a two-pass subranging conversion into one corrected 12-bit offset-binary sample. The first pass gives a coarse code. The block holds that code until the second pass delivers a fine code, which digitises the residue after a gain of 32. The two codes overlap on purpose. The block adds them with the coarse code weighted by 32 and removes a fixed digital offset of 48. Because of this redundancy, a coarse decision that is off by one step is absorbed by the fine code.

A corrected value outside the 12-bit range is clamped to the nearest end of the scale. The block then raises an overflow flag and reports which end was exceeded. Each pass has its own strobe. The corrected word, the two flags and a one-cycle valid pulse are registered on the clock edge that samples the fine strobe.

Top module: `subrange_corrector`

## Requirements
- R1: While reset is asserted (rst_n low), result, ovf, ovf_pos and valid are all 0, and no coarse code is held.
- R2: When coarse×32 + fine − 48 lies in 0..4095, result equals that value and ovf = ovf_pos = 0. Coarse 64 with fine 48 gives mid-scale, 2048.
- R3: When coarse×32 + fine − 48 exceeds 4095, result is 4095 (all ones), ovf = 1 and ovf_pos = 1.
- R4: When coarse×32 + fine − 48 is below 0, result is 0, ovf = 1 and ovf_pos = 0.
- R5: The outputs take the corrected value on the clock edge that samples an accepted fine_stb. valid is 1 in the cycle that follows that edge and 0 in every other cycle.
- R6: A captured coarse code stays held through any number of idle cycles. If coarse_stb is high again before the fine strobe, the later code replaces the earlier one.
- R7: A fine_stb with no coarse code held is ignored: valid stays 0 and result, ovf and ovf_pos keep their values.
- R8: Each held coarse code is used by exactly one fine_stb. A second fine_stb with no new coarse_stb is ignored.
- R9: When coarse_stb and fine_stb are high in the same cycle, the fine code combines with the code held before that cycle. The new coarse code becomes the held code.
- R10: result, ovf and ovf_pos change only on an edge that produces a valid pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| coarse_stb | input | 1 | First-pass code strobe |
| coarse_code | input | 7 | First-pass code |
| fine_stb | input | 1 | Second-pass code strobe |
| fine_code | input | 7 | Second-pass residue code |
| result | output | 12 | Corrected offset-binary sample |
| ovf | output | 1 | Result was clamped |
| ovf_pos | output | 1 | Clamp side: 1 = above full scale, 0 = below zero |
| valid | output | 1 | One-cycle pulse for a new result |

## Verification
The code pairs are chosen to probe the arithmetic. Mid-scale checks the weight and the offset together. Two different pairs that give the same sum (coarse 10/fine 80 and coarse 11/fine 48) show that the overlap is handled. Each end of the scale is tried at its exact limit and one step past it, which separates a correct clamp from an off-by-one error and a wrong polarity. Strobe orderings are tried as well: a fine strobe with no coarse code, a repeated fine strobe, coarse codes held across gaps or overwritten, both strobes in the same cycle, and a reset between the passes. Together they show whether the held code is captured, kept and used up correctly.

// File: rtl/sr_corr_pkg.sv
package sr_corr_pkg;
  typedef struct packed {
    logic hit;   // value was clamped
    logic high;  // clamp side: 1 = top of scale
  } clamp_flags_t;
endpackage

// File: rtl/sr_coarse_hold.sv
module sr_coarse_hold #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] load_code,
  input  logic              consume,
  output logic [CODE_W-1:0] held_code,
  output logic              held_ok
);
  logic [CODE_W-1:0] code_nxt;
  logic              ok_nxt;

  always_comb begin
    code_nxt = held_code;
    ok_nxt   = held_ok;
    if (consume) ok_nxt = 1'b0;
    if (load) begin
      code_nxt = load_code;
      ok_nxt   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_code <= '0;
      held_ok   <= 1'b0;
    end else begin
      held_code <= code_nxt;
      held_ok   <= ok_nxt;
    end
  end
endmodule

// File: rtl/sr_combine.sv
module sr_combine #(
  parameter int CODE_W     = 7,
  parameter int GAIN_SHIFT = 5,
  parameter int OFFSET     = 48,
  parameter int SUM_W      = 14
) (
  input  logic [CODE_W-1:0]       coarse,
  input  logic [CODE_W-1:0]       fine,
  output logic signed [SUM_W-1:0] sum
);
  logic signed [SUM_W-1:0] coarse_w;
  logic signed [SUM_W-1:0] fine_w;
  logic signed [SUM_W-1:0] offs_w;

  always_comb begin
    coarse_w = SUM_W'(coarse);
    coarse_w = coarse_w <<< GAIN_SHIFT;
    fine_w   = SUM_W'(fine);
    offs_w   = SUM_W'(OFFSET);
    sum      = coarse_w + fine_w - offs_w;
  end
endmodule

// File: rtl/sr_clamp.sv
module sr_clamp
  import sr_corr_pkg::*;
#(
  parameter int SUM_W = 14,
  parameter int OUT_W = 12
) (
  input  logic signed [SUM_W-1:0] sum,
  output logic [OUT_W-1:0]        code,
  output clamp_flags_t            flags
);
  localparam logic signed [SUM_W-1:0] TOP = SUM_W'((1 << OUT_W) - 1);

  always_comb begin
    code       = sum[OUT_W-1:0];
    flags.hit  = 1'b0;
    flags.high = 1'b0;
    if (sum < 0) begin
      code       = '0;
      flags.hit  = 1'b1;
    end else if (sum > TOP) begin
      code       = '1;
      flags.hit  = 1'b1;
      flags.high = 1'b1;
    end
  end
endmodule

// File: rtl/subrange_corrector.sv
module subrange_corrector
  import sr_corr_pkg::*;
#(
  parameter int CODE_W     = 7,
  parameter int GAIN_SHIFT = 5,
  parameter int OFFSET     = 48,
  parameter int OUT_W      = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coarse_stb,
  input  logic [CODE_W-1:0] coarse_code,
  input  logic              fine_stb,
  input  logic [CODE_W-1:0] fine_code,
  output logic [OUT_W-1:0]  result,
  output logic              ovf,
  output logic              ovf_pos,
  output logic              valid
);
  localparam int SUM_W = CODE_W + GAIN_SHIFT + 2;

  logic [CODE_W-1:0]       held_code;
  logic                    held_ok;
  logic                    accept;
  logic signed [SUM_W-1:0] sum;
  logic [OUT_W-1:0]        clamp_code;
  clamp_flags_t            clamp_fl;

  logic [OUT_W-1:0] result_nxt;
  logic             ovf_nxt, pos_nxt;

  assign accept = fine_stb & held_ok;

  sr_coarse_hold #(.CODE_W(CODE_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (coarse_stb),
    .load_code (coarse_code),
    .consume   (accept),
    .held_code (held_code),
    .held_ok   (held_ok)
  );

  sr_combine #(
    .CODE_W(CODE_W), .GAIN_SHIFT(GAIN_SHIFT), .OFFSET(OFFSET), .SUM_W(SUM_W)
  ) u_comb (
    .coarse (held_code),
    .fine   (fine_code),
    .sum    (sum)
  );

  sr_clamp #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_clamp (
    .sum   (sum),
    .code  (clamp_code),
    .flags (clamp_fl)
  );

  always_comb begin
    result_nxt = result;
    ovf_nxt    = ovf;
    pos_nxt    = ovf_pos;
    if (accept) begin
      result_nxt = clamp_code;
      ovf_nxt    = clamp_fl.hit;
      pos_nxt    = clamp_fl.high;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result  <= '0;
      ovf     <= 1'b0;
      ovf_pos <= 1'b0;
      valid   <= 1'b0;
    end else begin
      result  <= result_nxt;
      ovf     <= ovf_nxt;
      ovf_pos <= pos_nxt;
      valid   <= accept;
    end
  end
endmodule

// File: rtl/sr_corr_checker.sv
module sr_corr_checker #(
  parameter int OUT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fine_stb,
  input logic [OUT_W-1:0] result,
  input logic             ovf,
  input logic             ovf_pos,
  input logic             valid
);
  localparam logic [OUT_W-1:0] FULL = '1;

  assert_sat_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && ovf_pos) |-> (result == FULL));

  assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovf_pos) |-> (result == '0));

  assert_pol_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> !ovf_pos);

  assert_valid_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> $past(fine_stb));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(result) && $stable(ovf) && $stable(ovf_pos)));
endmodule

bind subrange_corrector sr_corr_checker #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .fine_stb (fine_stb),
  .result   (result),
  .ovf      (ovf),
  .ovf_pos  (ovf_pos),
  .valid    (valid)
);

// File: tb/test_subrange_corrector.sv
module test_subrange_corrector;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coarse_stb = 1'b0;
  logic [6:0] coarse_code = '0;
  logic       fine_stb = 1'b0;
  logic [6:0] fine_code = '0;
  logic [11:0] result;
  logic       ovf, ovf_pos, valid;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  int m_held = 0;
  bit m_has  = 0;
  int m_res  = 0;
  bit m_ovf  = 0;
  bit m_pos  = 0;
  bit m_val  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subrange_corrector i_subrange_corrector (
    .clk(clk), .rst_n(rst_n),
    .coarse_stb(coarse_stb), .coarse_code(coarse_code),
    .fine_stb(fine_stb), .fine_code(fine_code),
    .result(result), .ovf(ovf), .ovf_pos(ovf_pos), .valid(valid)
  );

  task automatic compare(input string tag);
    checks++;
    if (result !== 12'(m_res) || ovf !== m_ovf || ovf_pos !== m_pos || valid !== m_val) begin
      errors++;
      $display("FAIL %s: got res=%0d ovf=%0b pos=%0b val=%0b exp res=%0d ovf=%0b pos=%0b val=%0b",
               tag, result, ovf, ovf_pos, valid, m_res, m_ovf, m_pos, m_val);
    end
  endtask

  // drive one cycle of strobes, advance model at the edge, compare after it
  task automatic step(input bit cs, input int cc, input bit fs, input int fc, input string tag);
    int v;
    coarse_stb  = cs;
    coarse_code = 7'(cc);
    fine_stb    = fs;
    fine_code   = 7'(fc);
    @(posedge clk);
    m_val = 0;
    if (fs && m_has) begin
      v = m_held * 32 + fc - 48;
      m_val = 1;
      if (v > 4095) begin m_res = 4095; m_ovf = 1; m_pos = 1; end
      else if (v < 0) begin m_res = 0; m_ovf = 1; m_pos = 0; end
      else begin m_res = v; m_ovf = 0; m_pos = 0; end
      m_has = 0;
    end
    if (cs) begin m_held = cc; m_has = 1; end
    @(negedge clk);
    coarse_stb = 0;
    fine_stb   = 0;
    compare(tag);
  endtask

  task automatic convert(input int cc, input int fc, input string tag);
    step(1, cc, 0, 0, tag);
    step(0, 0, 1, fc, tag);
    step(0, 0, 0, 0, tag);  // valid must drop, outputs hold
  endtask

  task automatic do_reset();
    rst_n = 0;
    m_has = 0; m_res = 0; m_ovf = 0; m_pos = 0; m_val = 0;
    @(negedge clk);
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    checks++;
    errors++;
    $display("FAIL watchdog: got hang exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    step(0, 0, 0, 0, "R1 idle after reset");

    // R2 mid-scale and in-range values
    convert(64, 48, "R2 mid-scale 2048");
    convert(0, 48, "R2 zero edge");
    convert(127, 79, "R2 top edge 4095");
    convert(10, 80, "R2 overlap A");
    convert(11, 48, "R2 overlap B");
    convert(37, 5, "R2 arbitrary");

    // R3 above full scale
    convert(127, 80, "R3 one past top");
    convert(127, 127, "R3 max input");
    // R4 below zero
    convert(0, 47, "R4 one below zero");
    convert(0, 0, "R4 min input");
    convert(1, 0, "R4 coarse 1 fine 0");

    // R7 fine strobe with nothing held
    step(0, 0, 1, 100, "R7 orphan fine");
    step(0, 0, 0, 0, "R7 outputs kept");

    // R8 repeated fine
    step(1, 20, 0, 0, "R8 load");
    step(0, 0, 1, 60, "R8 first fine");
    step(0, 0, 1, 61, "R8 second fine ignored");
    step(0, 0, 0, 0, "R8 hold");

    // R6 hold across gaps, latest wins
    step(1, 30, 0, 0, "R6 load first");
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, "R6 gap");
    step(1, 90, 0, 0, "R6 overwrite");
    step(0, 0, 0, 0, "R6 gap");
    step(0, 0, 1, 70, "R6 latest used");

    // R9 simultaneous strobes
    step(1, 50, 0, 0, "R9 preload");
    step(1, 100, 1, 33, "R9 uses old code");
    step(0, 0, 1, 20, "R9 new code held");
    step(1, 5, 1, 9, "R9 same cycle nothing held");
    step(0, 0, 1, 9, "R9 then fine");

    // back-to-back valid pulses, R5
    step(1, 3, 0, 0, "R5 load");
    step(1, 4, 1, 1, "R5 pulse one");
    step(1, 6, 1, 2, "R5 pulse two");
    step(0, 0, 1, 3, "R5 pulse three");
    step(0, 0, 0, 0, "R5 drop");

    // R1 reset between passes drops held code
    step(1, 77, 0, 0, "R1 load before reset");
    do_reset();
    step(0, 0, 1, 50, "R1 held cleared");
    step(0, 0, 0, 0, "R10 idle hold");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule